// File: doc/BRIEF.md
# Synchronous Burst SRAM Front-End

This block is the control and address path of a pipelined synchronous cache RAM with 18-bit words. Each word holds two 9-bit lanes, and each lane carries 8 data bits and 1 parity bit. A burst starts when the processor strobe or the controller strobe captures an address. A 2-bit counter then supplies the low address bits of the following beats. The counter wraps within an aligned group of four. It steps in linear order or in interleaved order, as set by a mode pin. Each beat needs its own advance request.

Writes are taken on the clock edge. The data and the write controls present at that edge go to the current burst address, so no separate write strobe timing is needed. A global write stores the whole word. Byte-lane selects, together with a byte-write enable, store a single lane. Read data comes from a registered stage one clock after the address is registered. The data bus is common I/O, so the block drives it only when its own selection, the asynchronous output enable and the sleep input all allow it. The storage array is a small behavioural memory inside the block.

Top module: `burst_sram_front`

## Requirements
- R1: After reset the bus drive enable `dq_oe` is low and stays low until a selected read has completed.
- R2: On a rising edge where `sleep` is low, a start happens if `cpu_ads` is high with the chip selected, or if `ctl_ads` is high. A start loads `addr_i` into the address register and takes precedence over `adv`. The word at that address appears on `dq_o` after the next rising edge.
- R3: With `mode_ilv` low, beat n of a burst (n = 0..3) reads or writes low address bits (s + n) mod 4, where s is the low two bits of the start address. The upper bits keep their start value.
- R4: With `mode_ilv` high, beat n uses low address bits s XOR n. The upper bits keep their start value.
- R5: The burst address moves to the next beat only on an edge where `adv` is high and no start happens. Otherwise it holds.
- R6: A high `glob_wr` writes all 18 bits of `dq_i` to the current address, whatever `byte_wr` and `lane_sel` are.
- R7: With `glob_wr` low, lane k is written only when `byte_wr` and `lane_sel[k]` are both high. Lane 0 is bits 8:0 and lane 1 is bits 17:9. An unwritten lane keeps its old contents.
- R8: The chip is selected when `ce_a`=1, `ce_b`=1 and `ce_c_n`=0. A `cpu_ads` pulse while the chip is not selected has no effect on the address, the selection or the data read.
- R9: A start by `ctl_ads` while the chip is not selected deselects the block. It then neither drives the bus nor performs writes until a selected start occurs.
- R10: `dq_oe` is high only after an edge that had a registered selection and no write. Dropping `oe` clears `dq_oe` at once, without waiting for a clock edge.
- R11: While `sleep` is high, `dq_oe` is low at once. On those edges the strobes, `adv` and the write controls are ignored, so neither the address nor the memory changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr_i | input | ADDR_W | Burst start address |
| cpu_ads | input | 1 | Processor address strobe (needs chip selected) |
| ctl_ads | input | 1 | Cache controller address strobe |
| adv | input | 1 | Advance to next burst beat |
| mode_ilv | input | 1 | 1 = interleaved order, 0 = linear order |
| glob_wr | input | 1 | Write whole word |
| byte_wr | input | 1 | Byte-lane write enable |
| lane_sel | input | 2 | Per-lane write selects |
| ce_a | input | 1 | Chip enable, active high |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Low-power hold, outputs float |
| dq_i | input | 2*LANE_W | Write data from the common bus |
| dq_o | output | 2*LANE_W | Read data to the common bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The bench builds the block with `ADDR_W`=4, which gives a 16-word array. With that size every address can be pre-filled with a distinct value. It then reads every start offset and every upper-address group in both burst orders, so a wrong beat order cannot hide behind a write and a read that share the same error. All 16 combinations of the write controls are applied to one word over a known background, which covers lane masking and the priority of the global write. Short directed sequences cover the ignored processor strobe, deselection, output-enable gating and a sleep cycle in the middle of a burst.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

  // Low address bits for a given beat of a 4-beat wrap-around burst.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic       ilv);
    return ilv ? (start ^ beat) : (start + beat);
  endfunction

  // Lane write request: global write overrides the per-lane select.
  function automatic logic lane_write(input logic glob, input logic bwe,
                                      input logic sel);
    return glob | (bwe & sel);
  endfunction

endpackage

// File: rtl/bsram_burst_ctr.sv
module bsram_burst_ctr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       step,
  input  logic [1:0] start_low,
  input  logic       ilv,
  output logic [1:0] beat_o,
  output logic [1:0] low_o
);
  logic [1:0] start_q;
  logic [1:0] beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 2'd0;
      beat_q  <= 2'd0;
    end else if (load) begin
      start_q <= start_low;
      beat_q  <= 2'd0;
    end else if (step) begin
      beat_q  <= beat_q + 2'd1;
    end
  end

  assign beat_o = beat_q;
  assign low_o  = bsram_pkg::burst_low(start_q, beat_q, ilv);
endmodule

// File: rtl/bsram_lane_mem.sv
module bsram_lane_mem #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/burst_sram_front.sv
module burst_sram_front #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  cpu_ads,
  input  logic                  ctl_ads,
  input  logic                  adv,
  input  logic                  mode_ilv,
  input  logic                  glob_wr,
  input  logic                  byte_wr,
  input  logic [1:0]            lane_sel,
  input  logic                  ce_a,
  input  logic                  ce_b,
  input  logic                  ce_c_n,
  input  logic                  oe,
  input  logic                  sleep,
  input  logic [2*LANE_W-1:0]   dq_i,
  output logic [2*LANE_W-1:0]   dq_o,
  output logic                  dq_oe
);
  localparam int LANES = 2;

  // Named events for the checker
  logic              sel_now;
  logic              start_evt;
  logic              adv_evt;
  logic              en_q;
  logic              drv_q;
  logic              wr_any;
  logic [1:0]        beat;
  logic [1:0]        low;
  logic [ADDR_W-1:2] base_hi;
  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  lane_we;

  assign sel_now   = ce_a & ce_b & ~ce_c_n;
  assign start_evt = ~sleep & ((cpu_ads & sel_now) | ctl_ads);
  assign adv_evt   = ~sleep & ~start_evt & adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi <= '0;
      en_q    <= 1'b0;
      drv_q   <= 1'b0;
    end else begin
      if (start_evt) begin
        base_hi <= addr_i[ADDR_W-1:2];
        en_q    <= sel_now;
      end
      drv_q <= en_q & ~sleep & ~wr_any;
    end
  end

  bsram_burst_ctr u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_evt),
    .step      (adv_evt),
    .start_low (addr_i[1:0]),
    .ilv       (mode_ilv),
    .beat_o    (beat),
    .low_o     (low)
  );

  assign cur_addr = {base_hi, low};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_we[k] = ~sleep & en_q &
                        bsram_pkg::lane_write(glob_wr, byte_wr, lane_sel[k]);
    bsram_lane_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_mem (
      .clk   (clk),
      .we    (lane_we[k]),
      .addr  (cur_addr),
      .wdata (dq_i[k*LANE_W +: LANE_W]),
      .rdata (dq_o[k*LANE_W +: LANE_W])
    );
  end

  assign wr_any = |lane_we;
  assign dq_oe  = drv_q & oe & ~sleep;
endmodule

// File: rtl/bsram_front_chk.sv
module bsram_front_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ads,
  input logic              ctl_ads,
  input logic              adv,
  input logic              sleep,
  input logic              sel_now,
  input logic              start_evt,
  input logic              adv_evt,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [1:0]        beat,
  input logic              en_q,
  input logic              wr_any,
  input logic              dq_oe
);
  // R2
  start_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> cur_addr == $past(addr_i));

  // R5
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_evt && !adv_evt) |=> $stable(beat));

  // R3
  step_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> beat == $past(beat) + 2'd1);

  // R11
  sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(beat) && $stable(en_q) && $stable(cur_addr[ADDR_W-1:2]));

  // R8
  cpu_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ads && !sel_now && !ctl_ads && !adv) |=>
      $stable(beat) && $stable(en_q) && $stable(cur_addr[ADDR_W-1:2]));

  // R9
  desel_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !dq_oe);

  // R10
  write_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> !dq_oe);
endmodule

bind burst_sram_front bsram_front_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_ads   (cpu_ads),
  .ctl_ads   (ctl_ads),
  .adv       (adv),
  .sleep     (sleep),
  .sel_now   (sel_now),
  .start_evt (start_evt),
  .adv_evt   (adv_evt),
  .addr_i    (addr_i),
  .cur_addr  (cur_addr),
  .beat      (beat),
  .en_q      (en_q),
  .wr_any    (wr_any),
  .dq_oe     (dq_oe)
);

// File: tb/burst_sram_front_tb.sv
`timescale 1ns/1ps
module burst_sram_front_tb;
  localparam int AW = 4;
  localparam int LW = 9;
  localparam int WW = 2 * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic cpu_ads = 0, ctl_ads = 0, adv = 0, mode_ilv = 0;
  logic glob_wr = 0, byte_wr = 0;
  logic [1:0] lane_sel = 2'b00;
  logic ce_a = 1, ce_b = 1, ce_c_n = 0, oe = 1, sleep = 0;
  logic [WW-1:0] dq_i = '0;
  logic [WW-1:0] dq_o;
  logic dq_oe;

  int total = 0;
  int bad = 0;
  logic [WW-1:0] model [DEPTH];

  always #2 clk = ~clk;

  burst_sram_front #(.ADDR_W(AW), .LANE_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .cpu_ads(cpu_ads),
    .ctl_ads(ctl_ads), .adv(adv), .mode_ilv(mode_ilv), .glob_wr(glob_wr),
    .byte_wr(byte_wr), .lane_sel(lane_sel), .ce_a(ce_a), .ce_b(ce_b),
    .ce_c_n(ce_c_n), .oe(oe), .sleep(sleep), .dq_i(dq_i), .dq_o(dq_o),
    .dq_oe(dq_oe)
  );

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
    finish_run();
  end

  task automatic chk(input string req, input logic [WW-1:0] act,
                     input logic [WW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] base,
                                              input int n, input logic ilv);
    logic [1:0] s;
    logic [1:0] nb;
    s  = base[1:0];
    nb = n[1:0];
    return {base[AW-1:2], (ilv ? (s ^ nb) : 2'((int'(s) + n) % 4))};
  endfunction

  task automatic start(input logic [AW-1:0] a, input logic use_cpu);
    addr_i = a;
    if (use_cpu) cpu_ads = 1; else ctl_ads = 1;
    tick();
    cpu_ads = 0; ctl_ads = 0;
  endtask

  task automatic write_single(input logic [AW-1:0] a, input logic [WW-1:0] d);
    start(a, 1'b0);
    glob_wr = 1; dq_i = d;
    tick();
    glob_wr = 0;
    model[a] = d;
  endtask

  task automatic read_single(input logic [AW-1:0] a, input string req);
    start(a, 1'b1);
    tick();
    chk(req, dq_o, model[a]);
  endtask

  initial begin
    @(negedge clk);
    tick();
    rst_n = 1;
    tick();
    // R1: no drive after reset
    chk("R1", {17'd0, dq_oe}, '0);

    // prefill every word with a distinct value
    for (int a = 0; a < DEPTH; a++) write_single(a[AW-1:0], WW'(a * 18'h0A3C5 + 18'h01234));
    // R10: drive off right after a write edge
    chk("R10 write", {17'd0, dq_oe}, '0);

    // R3 / R4: burst reads, every start offset, every upper group, both orders
    for (int ilv = 0; ilv < 2; ilv++)
      for (int b = 0; b < DEPTH; b++) begin
        mode_ilv = ilv[0];
        start(b[AW-1:0], b[0]);
        for (int n = 0; n < 4; n++) begin
          adv = 1;
          tick();
          chk(ilv ? "R4 read" : "R3 read", dq_o, model[beat_addr(b[AW-1:0], n, ilv[0])]);
        end
        adv = 0;
      end
    chk("R2 drive", {17'd0, dq_oe}, 18'd1);

    // R3 / R4: burst writes checked by single reads
    for (int ilv = 0; ilv < 2; ilv++)
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] base;
        base = AW'(s + 4 * (s + ilv));
        mode_ilv = ilv[0];
        start(base, s[0]);
        for (int n = 0; n < 4; n++) begin
          glob_wr = 1; adv = 1;
          dq_i = WW'(18'h15000 + ilv * 256 + s * 16 + n);
          model[beat_addr(base, n, ilv[0])] = dq_i;
          tick();
        end
        glob_wr = 0; adv = 0;
        mode_ilv = 0;
        for (int n = 0; n < 4; n++)
          read_single({base[AW-1:2], n[1:0]}, ilv ? "R4 write" : "R3 write");
      end

    // R5: address holds without adv
    start(4'd6, 1'b1);
    tick();
    chk("R5", dq_o, model[6]);
    tick();
    chk("R5", dq_o, model[6]);

    // R2: start wins over adv, both strobes together
    addr_i = 4'd9; cpu_ads = 1; ctl_ads = 1; adv = 1;
    tick();
    cpu_ads = 0; ctl_ads = 0; adv = 0;
    tick();
    chk("R2", dq_o, model[9]);

    // R6 / R7: all write-control combinations over a known background
    for (int c = 0; c < 16; c++) begin
      logic g, bw;
      logic [1:0] ls;
      logic [WW-1:0] exp;
      g = c[3]; bw = c[2]; ls = c[1:0];
      write_single(4'd5, {9'h155, 9'h0AA});
      start(4'd5, 1'b0);
      glob_wr = g; byte_wr = bw; lane_sel = ls; dq_i = {9'h0F0, 9'h10F};
      tick();
      glob_wr = 0; byte_wr = 0; lane_sel = 0;
      exp = {9'h155, 9'h0AA};
      if (g | (bw & ls[0])) exp[8:0]  = 9'h10F;
      if (g | (bw & ls[1])) exp[17:9] = 9'h0F0;
      model[5] = exp;
      read_single(4'd5, g ? "R6" : "R7");
    end

    // R8: processor strobe while unselected is ignored
    write_single(4'd1, 18'h2A5A5);
    write_single(4'd2, 18'h15A5A);
    start(4'd1, 1'b0);
    addr_i = 4'd2; cpu_ads = 1; ce_a = 0;
    tick();
    cpu_ads = 0; ce_a = 1;
    chk("R8", dq_o, model[1]);
    tick();
    chk("R8", dq_o, model[1]);
    chk("R8 drive", {17'd0, dq_oe}, 18'd1);

    // R10: asynchronous output enable
    oe = 0; #1;
    chk("R10 oe", {17'd0, dq_oe}, '0);
    oe = 1; #1;
    chk("R10 oe", {17'd0, dq_oe}, 18'd1);

    // R9: controller strobe while unselected deselects
    ce_b = 0;
    start(4'd1, 1'b0);
    ce_b = 1;
    tick();
    chk("R9 float", {17'd0, dq_oe}, '0);
    glob_wr = 1; dq_i = 18'h3FFFF;
    tick();
    glob_wr = 0;
    chk("R9 float", {17'd0, dq_oe}, '0);
    read_single(4'd1, "R9 nowrite");

    // R11: sleep in mid-burst
    mode_ilv = 0;
    start(4'd4, 1'b1);
    adv = 1;
    tick();
    chk("R11 pre", dq_o, model[4]);
    sleep = 1; ctl_ads = 1; addr_i = 4'd12; glob_wr = 1; dq_i = 18'h3C3C3;
    #1;
    chk("R11 float", {17'd0, dq_oe}, '0);
    tick();
    sleep = 0; ctl_ads = 0; glob_wr = 0; adv = 1;
    tick();
    adv = 0;
    chk("R11 hold", dq_o, model[5]);
    read_single(4'd5, "R11 nowrite");
    read_single(4'd12, "R11 nowrite");

    finish_run();
  end
endmodule